// File: doc/BRIEF.md
# Pipeline Front-End Hazard Interlock and Flush Controller

This block supervises the front end of a five-stage in-order pipeline. It holds three pieces of state: the program counter, the register between fetch and decode, and the control-bit register between decode and execute. Each cycle, a combinational detector looks at the instruction now in execute and the one now in decode. It then picks one of three actions: RUN, STALL or REDIRECT. That action gates how the three registers update on the next rising edge.

The action is chosen in this order:
- **REDIRECT** is selected whenever the branch-taken input is high, for a taken conditional branch or any jump.
- **STALL** is selected when there is no redirect but the execute-stage instruction is a load whose nonzero destination index matches either decode source index.
- **RUN** is selected in all other cases.

Fetch follows static predict-not-taken, so under RUN the PC steps by 4. The action is combinational and carries no state, so a STALL lasts exactly as long as the load-use match is present. In a normal pipeline the load has moved on to memory one cycle later, so exactly one bubble is inserted.

The action transitions are RUN→STALL when a load-use match appears, STALL→RUN when it clears, any action→REDIRECT when the branch flag rises, and REDIRECT→RUN when it falls. The three gating outputs are also brought out to drive the rest of the front end.

Top module: `hazard_frontend`

## Requirements
- R1: A load-use match forces STALL, giving pc_wr_en=0, fd_wr_en=0 and dx_clear=1, with fd_clear=0. A load-use match means ex_is_load=1, ex_dst≠0, and ex_dst equal to dec_src_a or to dec_src_b.
- R2: A load whose destination index is 0 never causes a stall. With no redirect, the gates are pc_wr_en=1, fd_wr_en=1, fd_clear=0 and dx_clear=0.
- R3: A non-load instruction in execute never causes a stall, even when its destination matches a decode source.
- R4: In a STALL cycle, at the next edge pc_out and fd_word keep their values and dx_ctrl becomes all zeros.
- R5: In a RUN cycle, at the next edge pc_out increases by 4, fd_word loads fetch_word, and dx_ctrl loads dec_ctrl.
- R6: When redirect_taken=1, at the next edge pc_out loads redirect_target, and both fd_word and dx_ctrl become all zeros.
- R7: When a redirect and a load-use match occur in the same cycle, the redirect wins. The gates are pc_wr_en=1, fd_clear=1 and dx_clear=1, and the state updates as in R6. A fetch/decode clear overrides a deasserted write enable.
- R8: A synchronous active-high rst sets pc_out to 0x00000000, fd_word to 0 and dx_ctrl to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | 5 | Execute-stage destination index |
| dec_src_a | input | 5 | Decode-stage first source index |
| dec_src_b | input | 5 | Decode-stage second source index |
| redirect_taken | input | 1 | Taken branch or jump resolved in execute |
| redirect_target | input | 32 | Redirect destination address |
| fetch_word | input | 32 | Instruction word from fetch |
| dec_ctrl | input | 8 | Decoded control bits entering decode/execute register |
| pc_out | output | 32 | Current program counter |
| fd_word | output | 32 | Latched fetch/decode instruction |
| dx_ctrl | output | 8 | Execute-stage control bits |
| pc_wr_en | output | 1 | PC update enable |
| fd_wr_en | output | 1 | Fetch/decode register write enable |
| fd_clear | output | 1 | Fetch/decode synchronous clear |
| dx_clear | output | 1 | Decode/execute synchronous clear (bubble) |

## Verification
The hardest case to reach is a redirect and a load-use match arriving in the same cycle. In that cycle the branch must win, even though the stall condition would freeze the fetch/decode register. The stimulus reaches it in two ways. A directed step raises the branch flag while a load to a matching nonzero register sits in execute. A long pseudo-random phase then draws indices from a narrow range of 0 to 3, so that matches, loads to x0 and coincident redirects all happen often. A behavioural reference model is compared against both the gates and the registered state on every cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        ACT_RUN      = 2'd0,
        ACT_STALL    = 2'd1,
        ACT_REDIRECT = 2'd2
    } hz_action_e;
endpackage

// File: rtl/hz_detect.sv
module hz_detect #(
    parameter int IDX_W = 5
) (
    input  logic             ex_is_load,
    input  logic [IDX_W-1:0] ex_dst,
    input  logic [IDX_W-1:0] dec_src_a,
    input  logic [IDX_W-1:0] dec_src_b,
    input  logic             redirect_taken,
    output hz_pkg::hz_action_e action,
    output logic             pc_wr_en,
    output logic             fd_wr_en,
    output logic             fd_clear,
    output logic             dx_clear
);
    import hz_pkg::*;

    logic dst_live;
    logic src_hit;
    logic load_use;

    always_comb begin
        dst_live = (ex_dst != '0);
        src_hit  = (ex_dst == dec_src_a) || (ex_dst == dec_src_b);
        load_use = ex_is_load && dst_live && src_hit;
        if (redirect_taken)  action = ACT_REDIRECT;
        else if (load_use)   action = ACT_STALL;
        else                 action = ACT_RUN;
    end

    always_comb begin
        unique case (action)
            ACT_REDIRECT: begin
                pc_wr_en = 1'b1;
                fd_wr_en = 1'b1;
                fd_clear = 1'b1;
                dx_clear = 1'b1;
            end
            ACT_STALL: begin
                pc_wr_en = 1'b0;
                fd_wr_en = 1'b0;
                fd_clear = 1'b0;
                dx_clear = 1'b1;
            end
            default: begin
                pc_wr_en = 1'b1;
                fd_wr_en = 1'b1;
                fd_clear = 1'b0;
                dx_clear = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hz_pc.sv
module hz_pc #(
    parameter int          XLEN   = 32,
    parameter logic [31:0] RST_PC = 32'h0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            take_target,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    always_ff @(posedge clk) begin
        if (rst)               pc <= RST_PC[XLEN-1:0];
        else if (take_target)  pc <= target;
        else if (wr_en)        pc <= pc + STEP;
    end
endmodule

// File: rtl/hz_stage_reg.sv
module hz_stage_reg #(
    parameter int W        = 32,
    parameter bit HAS_HOLD = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         wr_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic load;

    generate
        if (HAS_HOLD) begin : g_hold
            assign load = wr_en;
        end else begin : g_nohold
            logic unused_we;
            assign unused_we = wr_en;
            assign load = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) q <= '0;
        else if (load)    q <= d;
    end
endmodule

// File: rtl/hazard_frontend.sv
module hazard_frontend #(
    parameter int          XLEN   = 32,
    parameter int          IDX_W  = 5,
    parameter int          CTRL_W = 8,
    parameter logic [31:0] RST_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ex_is_load,
    input  logic [IDX_W-1:0]  ex_dst,
    input  logic [IDX_W-1:0]  dec_src_a,
    input  logic [IDX_W-1:0]  dec_src_b,
    input  logic              redirect_taken,
    input  logic [XLEN-1:0]   redirect_target,
    input  logic [XLEN-1:0]   fetch_word,
    input  logic [CTRL_W-1:0] dec_ctrl,
    output logic [XLEN-1:0]   pc_out,
    output logic [XLEN-1:0]   fd_word,
    output logic [CTRL_W-1:0] dx_ctrl,
    output logic              pc_wr_en,
    output logic              fd_wr_en,
    output logic              fd_clear,
    output logic              dx_clear
);
    import hz_pkg::*;

    hz_action_e action;
    logic       go_target;

    hz_detect #(.IDX_W(IDX_W)) u_detect (
        .ex_is_load     (ex_is_load),
        .ex_dst         (ex_dst),
        .dec_src_a      (dec_src_a),
        .dec_src_b      (dec_src_b),
        .redirect_taken (redirect_taken),
        .action         (action),
        .pc_wr_en       (pc_wr_en),
        .fd_wr_en       (fd_wr_en),
        .fd_clear       (fd_clear),
        .dx_clear       (dx_clear)
    );

    assign go_target = (action == ACT_REDIRECT);

    hz_pc #(.XLEN(XLEN), .RST_PC(RST_PC)) u_pc (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (pc_wr_en),
        .take_target (go_target),
        .target      (redirect_target),
        .pc          (pc_out)
    );

    hz_stage_reg #(.W(XLEN), .HAS_HOLD(1'b1)) u_fd (
        .clk   (clk),
        .rst   (rst),
        .clear (fd_clear),
        .wr_en (fd_wr_en),
        .d     (fetch_word),
        .q     (fd_word)
    );

    hz_stage_reg #(.W(CTRL_W), .HAS_HOLD(1'b0)) u_dx (
        .clk   (clk),
        .rst   (rst),
        .clear (dx_clear),
        .wr_en (1'b1),
        .d     (dec_ctrl),
        .q     (dx_ctrl)
    );
endmodule

// File: rtl/hazard_frontend_chk.sv
module hazard_frontend_chk #(
    parameter int XLEN   = 32,
    parameter int IDX_W  = 5,
    parameter int CTRL_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ex_is_load,
    input logic [IDX_W-1:0]  ex_dst,
    input logic [IDX_W-1:0]  dec_src_a,
    input logic [IDX_W-1:0]  dec_src_b,
    input logic              redirect_taken,
    input logic [XLEN-1:0]   redirect_target,
    input logic [XLEN-1:0]   pc_out,
    input logic [XLEN-1:0]   fd_word,
    input logic [CTRL_W-1:0] dx_ctrl,
    input logic              pc_wr_en,
    input logic              fd_wr_en,
    input logic              fd_clear,
    input logic              dx_clear
);
    p_stall_gates_r1: assert property (@(posedge clk) disable iff (rst)
        (ex_is_load && ex_dst != '0 && (ex_dst == dec_src_a || ex_dst == dec_src_b) && !redirect_taken)
        |-> (!pc_wr_en && !fd_wr_en && !fd_clear && dx_clear));

    p_x0_no_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (ex_dst == '0 && !redirect_taken) |-> (pc_wr_en && fd_wr_en && !dx_clear));

    p_nonload_no_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (!ex_is_load && !redirect_taken) |-> (pc_wr_en && fd_wr_en && !dx_clear));

    p_pc_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !pc_wr_en |=> $stable(pc_out));

    p_fd_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!fd_wr_en && !fd_clear) |=> $stable(fd_word));

    p_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        dx_clear |=> (dx_ctrl == '0));

    p_pc_step_r5: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_en && !redirect_taken) |=> (pc_out == $past(pc_out) + XLEN'(4)));

    p_redirect_r6: assert property (@(posedge clk) disable iff (rst)
        redirect_taken |=> (pc_out == $past(redirect_target) && fd_word == '0));

    p_branch_wins_r7: assert property (@(posedge clk) disable iff (rst)
        redirect_taken |-> (pc_wr_en && fd_clear && dx_clear));

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (pc_out == '0 && fd_word == '0 && dx_ctrl == '0));
endmodule

bind hazard_frontend hazard_frontend_chk #(
    .XLEN(XLEN), .IDX_W(IDX_W), .CTRL_W(CTRL_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .ex_is_load      (ex_is_load),
    .ex_dst          (ex_dst),
    .dec_src_a       (dec_src_a),
    .dec_src_b       (dec_src_b),
    .redirect_taken  (redirect_taken),
    .redirect_target (redirect_target),
    .pc_out          (pc_out),
    .fd_word         (fd_word),
    .dx_ctrl         (dx_ctrl),
    .pc_wr_en        (pc_wr_en),
    .fd_wr_en        (fd_wr_en),
    .fd_clear        (fd_clear),
    .dx_clear        (dx_clear)
);

// File: tb/hazard_frontend_bench.sv
`timescale 1ns/100ps
module hazard_frontend_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ex_is_load = 1'b0;
    logic [4:0]  ex_dst = '0;
    logic [4:0]  dec_src_a = '0;
    logic [4:0]  dec_src_b = '0;
    logic        redirect_taken = 1'b0;
    logic [31:0] redirect_target = '0;
    logic [31:0] fetch_word = '0;
    logic [7:0]  dec_ctrl = '0;
    logic [31:0] pc_out;
    logic [31:0] fd_word;
    logic [7:0]  dx_ctrl;
    logic        pc_wr_en, fd_wr_en, fd_clear, dx_clear;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_pc = '0;
    logic [31:0] m_fd = '0;
    logic [7:0]  m_ctl = '0;

    always #2.5 clk = ~clk;

    hazard_frontend u_hazard_frontend (
        .clk(clk), .rst(rst), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .redirect_taken(redirect_taken), .redirect_target(redirect_target),
        .fetch_word(fetch_word), .dec_ctrl(dec_ctrl),
        .pc_out(pc_out), .fd_word(fd_word), .dx_ctrl(dx_ctrl),
        .pc_wr_en(pc_wr_en), .fd_wr_en(fd_wr_en), .fd_clear(fd_clear), .dx_clear(dx_clear)
    );

    task automatic step(input logic r, input logic ld, input logic [4:0] dst,
                        input logic [4:0] sa, input logic [4:0] sb,
                        input logic br, input logic [31:0] tgt,
                        input logic [31:0] word, input logic [7:0] ctl,
                        input string tag);
        logic       hit;
        logic [3:0] eg, ag;
        @(negedge clk);
        rst = r; ex_is_load = ld; ex_dst = dst; dec_src_a = sa; dec_src_b = sb;
        redirect_taken = br; redirect_target = tgt; fetch_word = word; dec_ctrl = ctl;
        #1;
        hit = ld && (dst != 0) && (dst == sa || dst == sb);
        if (br)       eg = 4'b1111;
        else if (hit) eg = 4'b0001;
        else          eg = 4'b1100;
        ag = {pc_wr_en, fd_wr_en, fd_clear, dx_clear};
        checks++;
        if (ag !== eg) begin
            fails++;
            $display("FAIL %s gates {pcw,fdw,fdc,dxc}: got %b expected %b", tag, ag, eg);
        end
        if (r)        begin m_pc = 0;       m_fd = 0;    m_ctl = 0;   end
        else if (br)  begin m_pc = tgt;     m_fd = 0;    m_ctl = 0;   end
        else if (hit) begin                              m_ctl = 0;   end
        else          begin m_pc = m_pc + 4; m_fd = word; m_ctl = ctl; end
        @(posedge clk); #1;
        checks++;
        if (pc_out !== m_pc || fd_word !== m_fd || dx_ctrl !== m_ctl) begin
            fails++;
            $display("FAIL %s state: got pc=%h fd=%h ctl=%h expected pc=%h fd=%h ctl=%h",
                     tag, pc_out, fd_word, dx_ctrl, m_pc, m_fd, m_ctl);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        step(1, 0, 0, 0, 0, 0, 0, 32'h11, 8'h3C, "R8 reset");
        step(1, 0, 0, 0, 0, 0, 0, 32'h12, 8'h3C, "R8 reset hold");
        step(0, 0, 0, 1, 2, 0, 0, 32'hA000_0001, 8'h81, "R5 run");
        step(0, 0, 3, 1, 2, 0, 0, 32'hA000_0002, 8'h42, "R5 run");
        step(0, 1, 2, 2, 3, 0, 0, 32'hA000_0003, 8'hFF, "R1 rs1 stall R4");
        step(0, 0, 0, 2, 3, 0, 0, 32'hA000_0003, 8'h24, "R5 after bubble");
        step(0, 1, 7, 1, 7, 0, 0, 32'hA000_0004, 8'hFF, "R1 rs2 stall R4");
        step(0, 0, 0, 1, 7, 0, 0, 32'hA000_0004, 8'h18, "R5 after bubble");
        step(0, 1, 0, 0, 0, 0, 0, 32'hA000_0005, 8'h99, "R2 load x0");
        step(0, 0, 5, 5, 5, 0, 0, 32'hA000_0006, 8'h77, "R3 non-load match");
        step(0, 0, 0, 1, 2, 1, 32'h0000_0100, 32'hA000_0007, 8'hEE, "R6 redirect");
        step(0, 0, 0, 1, 2, 0, 0, 32'hB000_0000, 8'h5A, "R5 at target");
        step(0, 1, 9, 9, 4, 1, 32'h0000_0400, 32'hB000_0001, 8'hC3, "R7 branch plus load-use");
        step(0, 0, 0, 0, 0, 0, 0, 32'hB000_0002, 8'h01, "R5 after R7");
        step(0, 1, 6, 6, 6, 0, 0, 32'hB000_0003, 8'h02, "R4 stall hold");
        step(1, 1, 6, 6, 6, 0, 0, 32'hB000_0004, 8'h03, "R8 mid-run reset");
        for (int i = 0; i < 400; i++) begin
            step(0, 1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)),
                 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                 ($urandom_range(0, 5) == 0), $urandom & 32'hFFFF_FFFC,
                 $urandom, 8'($urandom), "R7 mixed");
        end
        finish_run();
    end
endmodule